// File: doc/BRIEF.md
# Line-Change Timestamping Engine

The engine watches a bank of asynchronous input lines and records every change of level as an event. Each event carries the line number, the new level and a copy of a free-running 64-bit system count that arrives as an input. Events collect in an internal 256-entry queue, and software drains that queue through a pop strobe. Software switches monitoring on or off for each line through an enable bitmap. The bitmap is written one 32-bit slice at a time, addressed by a slice number.

When several enabled lines change in the same cycle, all of them are caught at once and keep the same stamp. They then enter the queue one per cycle, lowest line number first. A level interrupt reports that the queue holds at least a programmable number of entries. A sticky flag records every event that could not be kept, and software clears it with a strobe.

Top module: `line_stamp_engine`

## Requirements
- R1: Each line passes through two synchronising flops. A change driven before rising edge k enters the queue at edge k+3, and is visible after that edge. Its stamp is the `sys_count_i` value present at edge k+2.
- R2: After reset every line is disabled. An enable write with slice number s < SLICES loads bits [32*s+31 : 32*s] of the bitmap from the data word. A write with a slice number at or above SLICES changes nothing. A change on a disabled line produces no event.
- R3: Changes detected in the same cycle share one stamp and enter the queue one per cycle, in ascending line order.
- R4: An event reports the line number on `evt_line_o`. It reports the level after the change on `evt_level_o`: 1 for a rising change, 0 for a falling change.
- R5: The queue holds 256 events and always shows its oldest entry on the event outputs while `evt_valid_o` is high. A pop removes that entry at the next edge, and a pop while the queue is empty does nothing. `fill_o` gives the current occupancy, and reset empties the queue.
- R6: The threshold resets to 1. A threshold write of 0 stores 1, and a write above 256 stores 256.
- R7: `irq_o` is high exactly while `fill_o` is at or above the threshold. It falls in the same cycle that a pop brings the occupancy below the threshold.
- R8: An event that finds the queue full is discarded, and `ovf_o` rises at the following edge. `ovf_o` stays high until `ovf_clr_i` is pulsed, and a new discard in the same cycle as a clear wins. Reset clears `ovf_o`.
- R9: A second change on a line whose earlier event is still waiting to enter the queue is discarded and sets `ovf_o`. The waiting event keeps its level and stamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lines_i | input | 96 | Monitored lines (SLICES*32), asynchronous |
| sys_count_i | input | 64 | Free-running system count used as the stamp |
| en_wr_i | input | 1 | Enable-bitmap write strobe |
| en_slice_i | input | 2 | Slice number for the enable write |
| en_data_i | input | 32 | Enable bits for the addressed slice |
| thr_wr_i | input | 1 | Threshold write strobe |
| thr_val_i | input | 9 | Threshold value to write (clamped to 1..256) |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| pop_i | input | 1 | Removes the oldest queued event |
| evt_valid_o | output | 1 | Queue holds at least one event |
| evt_line_o | output | 7 | Line number of the oldest event |
| evt_level_o | output | 1 | New level of the oldest event |
| evt_stamp_o | output | 64 | Stamp of the oldest event |
| fill_o | output | 9 | Queue occupancy, 0 to 256 |
| irq_o | output | 1 | Occupancy at or above the threshold |
| ovf_o | output | 1 | Sticky flag for discarded events |

## Verification
A line change driven before edge k appears in `fill_o` only after edge k+3. Its stamp must equal the count at edge k+2, so the bench predicts it as the count it reads while driving, plus two. Simultaneous changes follow at one entry per edge after that. `irq_o` follows `fill_o` in the same cycle, while `ovf_o` and the threshold take effect one edge after their cause. The bench drives and samples on falling edges, and it waits at least as many cycles as these latencies before each check. It also samples `fill_o` once at the third and once at the fourth falling edge after a change, which pins the exact entry cycle.

// File: rtl/lse_pkg.sv
`timescale 1ns/1ps
package lse_pkg;
    localparam int SLICE_W = 32;
    localparam int TS_W    = 64;
    localparam int THR_W   = 9;
    localparam int THR_MAX = 256;

    // Keep a written threshold inside 1..THR_MAX
    function automatic logic [THR_W-1:0] clamp_thr(input logic [THR_W-1:0] v);
        if (v == '0)
            return THR_W'(1);
        else if (int'(v) > THR_MAX)
            return THR_W'(THR_MAX);
        else
            return v;
    endfunction
endpackage

// File: rtl/lse_line_front.sv
`timescale 1ns/1ps
module lse_line_front #(
    parameter int N = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] edge_o,
    output logic [N-1:0] level_o
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] prev;
    } front_t;

    front_t front_q, front_d;

    always_comb begin
        front_d      = front_q;
        front_d.meta = lines_i;
        front_d.sync = front_q.meta;
        front_d.prev = front_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) front_q <= '0;
        else        front_q <= front_d;
    end

    // Change seen on the synchronised level, masked by the per-line enable
    assign edge_o  = (front_q.sync ^ front_q.prev) & en_i;
    assign level_o = front_q.sync;
endmodule

// File: rtl/lse_pending.sv
`timescale 1ns/1ps
module lse_pending #(
    parameter int N     = 96,
    parameter int IDX_W = 7,
    parameter int TS_W  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     edge_i,
    input  logic [N-1:0]     level_i,
    input  logic [TS_W-1:0]  stamp_i,
    output logic             sel_valid_o,
    output logic [IDX_W-1:0] sel_idx_o,
    output logic             sel_level_o,
    output logic [TS_W-1:0]  sel_stamp_o,
    output logic             collide_o
);
    typedef struct packed {
        logic [N-1:0]            pend;
        logic [N-1:0]            lvl;
        logic [N-1:0][TS_W-1:0]  stamp;
    } pend_t;

    pend_t           pend_q, pend_d;
    logic            found;
    logic [IDX_W-1:0] pick;
    logic [N-1:0]    gnt;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && pend_q.pend[i]) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end

        gnt = '0;
        for (int i = 0; i < N; i++) begin
            if (found && (pick == IDX_W'(i))) gnt[i] = 1'b1;
        end

        pend_d = pend_q;
        for (int i = 0; i < N; i++) begin
            if (edge_i[i] && !(pend_q.pend[i] && !gnt[i])) begin
                pend_d.pend[i]  = 1'b1;
                pend_d.lvl[i]   = level_i[i];
                pend_d.stamp[i] = stamp_i;
            end else if (gnt[i]) begin
                pend_d.pend[i] = 1'b0;
            end
        end

        collide_o = |(edge_i & pend_q.pend & ~gnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign sel_valid_o = found;
    assign sel_idx_o   = pick;
    assign sel_level_o = pend_q.lvl[pick];
    assign sel_stamp_o = pend_q.stamp[pick];

    // R3
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q.pend & $past(pend_q.pend & ~gnt)) == $past(pend_q.pend & ~gnt)));

    // R3
    grant_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid_o && $past(sel_valid_o) && ($past(edge_i) == '0))
            |-> (sel_idx_o > $past(sel_idx_o)));
endmodule

// File: rtl/lse_fifo.sv
`timescale 1ns/1ps
module lse_fifo #(
    parameter int W     = 72,
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [W-1:0]               data_i,
    input  logic                       pop_i,
    output logic [W-1:0]               data_o,
    output logic                       valid_o,
    output logic                       full_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_t;

    fifo_t      fifo_q, fifo_d;
    logic [W-1:0] mem [DEPTH];
    logic       do_push, do_pop;

    assign full_o  = (fifo_q.cnt == CNT_W'(DEPTH));
    assign valid_o = (fifo_q.cnt != '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && valid_o;

    always_comb begin
        fifo_d = fifo_q;
        if (do_push)
            fifo_d.wr = (fifo_q.wr == PTR_W'(DEPTH - 1)) ? '0 : fifo_q.wr + 1'b1;
        if (do_pop)
            fifo_d.rd = (fifo_q.rd == PTR_W'(DEPTH - 1)) ? '0 : fifo_q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   fifo_d.cnt = fifo_q.cnt + 1'b1;
            2'b01:   fifo_d.cnt = fifo_q.cnt - 1'b1;
            default: fifo_d.cnt = fifo_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[fifo_q.wr] <= data_i;
    end

    assign data_o  = mem[fifo_q.rd];
    assign count_o = fifo_q.cnt;

    // R5
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_o) <= DEPTH);

    // R5
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o && !pop_i) |=> (int'(count_o) == int'($past(count_o)) + 1));

    // R5
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && valid_o && !push_i) |=> (int'(count_o) == int'($past(count_o)) - 1));
endmodule

// File: rtl/line_stamp_engine.sv
`timescale 1ns/1ps
module line_stamp_engine
    import lse_pkg::*;
#(
    parameter int SLICES = 3,
    parameter int DEPTH  = 256
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [SLICES*SLICE_W-1:0]         lines_i,
    input  logic [TS_W-1:0]                   sys_count_i,
    input  logic                              en_wr_i,
    input  logic [((SLICES>1)?$clog2(SLICES):1)-1:0] en_slice_i,
    input  logic [SLICE_W-1:0]                en_data_i,
    input  logic                              thr_wr_i,
    input  logic [THR_W-1:0]                  thr_val_i,
    input  logic                              ovf_clr_i,
    input  logic                              pop_i,
    output logic                              evt_valid_o,
    output logic [$clog2(SLICES*SLICE_W)-1:0] evt_line_o,
    output logic                              evt_level_o,
    output logic [TS_W-1:0]                   evt_stamp_o,
    output logic [$clog2(DEPTH+1)-1:0]        fill_o,
    output logic                              irq_o,
    output logic                              ovf_o
);
    localparam int N     = SLICES * SLICE_W;
    localparam int IDX_W = $clog2(N);
    localparam int EW    = IDX_W + 1 + TS_W;

    typedef struct packed {
        logic [N-1:0]     en;
        logic [THR_W-1:0] thr;
        logic             ovf;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [N-1:0]     edges, levels;
    logic             sel_valid, sel_level, collide, q_full;
    logic [IDX_W-1:0] sel_idx;
    logic [TS_W-1:0]  sel_stamp;
    logic [EW-1:0]    q_head;
    logic             drop;

    lse_line_front #(.N(N)) u_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (lines_i),
        .en_i    (ctl_q.en),
        .edge_o  (edges),
        .level_o (levels)
    );

    lse_pending #(.N(N), .IDX_W(IDX_W), .TS_W(TS_W)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_i      (edges),
        .level_i     (levels),
        .stamp_i     (sys_count_i),
        .sel_valid_o (sel_valid),
        .sel_idx_o   (sel_idx),
        .sel_level_o (sel_level),
        .sel_stamp_o (sel_stamp),
        .collide_o   (collide)
    );

    lse_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (sel_valid),
        .data_i  ({sel_idx, sel_level, sel_stamp}),
        .pop_i   (pop_i),
        .data_o  (q_head),
        .valid_o (evt_valid_o),
        .full_o  (q_full),
        .count_o (fill_o)
    );

    assign drop = (sel_valid && q_full) || collide;

    always_comb begin
        ctl_d = ctl_q;
        if (en_wr_i && (int'(en_slice_i) < SLICES))
            ctl_d.en[int'(en_slice_i)*SLICE_W +: SLICE_W] = en_data_i;
        if (thr_wr_i)
            ctl_d.thr = clamp_thr(thr_val_i);
        if (ovf_clr_i)
            ctl_d.ovf = 1'b0;
        if (drop)
            ctl_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.thr <= THR_W'(1);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign evt_line_o  = q_head[EW-1 -: IDX_W];
    assign evt_level_o = q_head[TS_W];
    assign evt_stamp_o = q_head[TS_W-1:0];
    assign irq_o       = (int'(fill_o) >= int'(ctl_q.thr));
    assign ovf_o       = ctl_q.ovf;

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && q_full) |=> ovf_o);

    // R9
    collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> ovf_o);

    // R6
    thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ctl_q.thr) >= 1) && (int'(ctl_q.thr) <= THR_MAX));
endmodule

// File: tb/sim_line_stamp_engine.sv
`timescale 1ns/1ps
module sim_line_stamp_engine;
    localparam int SLICES = 3;
    localparam int N      = SLICES * 32;
    localparam int DEPTH  = 256;

    typedef struct {
        int     line;
        bit     lvl;
        longint st;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  lines_i = '0;
    logic [63:0]   cnt = '0;
    logic          en_wr_i = 1'b0;
    logic [1:0]    en_slice_i = '0;
    logic [31:0]   en_data_i = '0;
    logic          thr_wr_i = 1'b0;
    logic [8:0]    thr_val_i = '0;
    logic          ovf_clr_i = 1'b0;
    logic          pop_i = 1'b0;
    logic          evt_valid_o, evt_level_o, irq_o, ovf_o;
    logic [6:0]    evt_line_o;
    logic [63:0]   evt_stamp_o;
    logic [8:0]    fill_o;

    exp_t    exp_q[$];
    bit [N-1:0] en_m = '0;
    bit [N-1:0] lv_m = '0;
    bit      mon_en = 1'b0;
    int      man_pops = 0;
    int      checks = 0;
    int      errors = 0;
    bit      done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 64'd1;

    line_stamp_engine #(.SLICES(SLICES), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .lines_i(lines_i), .sys_count_i(cnt),
        .en_wr_i(en_wr_i), .en_slice_i(en_slice_i), .en_data_i(en_data_i),
        .thr_wr_i(thr_wr_i), .thr_val_i(thr_val_i), .ovf_clr_i(ovf_clr_i),
        .pop_i(pop_i), .evt_valid_o(evt_valid_o), .evt_line_o(evt_line_o),
        .evt_level_o(evt_level_o), .evt_stamp_o(evt_stamp_o), .fill_o(fill_o),
        .irq_o(irq_o), .ovf_o(ovf_o)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit [N-1:0] one(int i);
        bit [N-1:0] v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_en(int s, logic [31:0] v);
        @(negedge clk);
        en_wr_i = 1'b1; en_slice_i = 2'(s); en_data_i = v;
        if (s < SLICES) en_m[s*32 +: 32] = v;
        @(negedge clk);
        en_wr_i = 1'b0;
    endtask

    task automatic wr_thr(int v);
        @(negedge clk);
        thr_wr_i = 1'b1; thr_val_i = 9'(v);
        @(negedge clk);
        thr_wr_i = 1'b0;
    endtask

    task automatic clr_ovf();
        @(negedge clk);
        ovf_clr_i = 1'b1;
        @(negedge clk);
        ovf_clr_i = 1'b0;
    endtask

    // Driver: flips the masked lines and predicts the resulting events
    task automatic toggle(bit [N-1:0] m, int settle, bit lost);
        @(negedge clk);
        lines_i = lines_i ^ m;
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                lv_m[i] = ~lv_m[i];
                if (en_m[i] && !lost && exp_q.size() < DEPTH)
                    exp_q.push_back('{line: i, lvl: lv_m[i], st: longint'(cnt) + 2});
            end
        end
        tick(settle);
    endtask

    // Monitor: compares the queue head with the oldest prediction and pops it
    always @(negedge clk) begin
        pop_i <= 1'b0;
        if (rst_n && evt_valid_o && (mon_en || man_pops > 0)) begin
            if (exp_q.size() == 0) begin
                chk("R2", "unexpected event line", longint'(evt_line_o), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R3", "event line order", longint'(evt_line_o), e.line);
                chk("R4", "event level", longint'(evt_level_o), longint'(e.lvl));
                chk("R1", "event stamp", longint'(evt_stamp_o), e.st);
            end
            pop_i <= 1'b1;
            if (man_pops > 0) man_pops--;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        // R5 R7 R8 reset state
        chk("R5", "valid in reset", longint'(evt_valid_o), 0);
        chk("R5", "fill in reset", longint'(fill_o), 0);
        chk("R7", "irq in reset", longint'(irq_o), 0);
        chk("R8", "ovf in reset", longint'(ovf_o), 0);
        rst_n = 1'b1;
        tick(2);

        // R1 entry timing, R7 threshold 1 (R6 default)
        wr_en(0, 32'hFFFF_FFFF);
        toggle(one(5), 0, 1'b0);
        tick(3);
        chk("R1", "fill before fourth edge", longint'(fill_o), 0);
        tick(1);
        chk("R1", "fill after fourth edge", longint'(fill_o), 1);
        chk("R6", "irq with default threshold", longint'(irq_o), 1);
        man_pops = 1;
        tick(2);
        chk("R7", "irq after pop", longint'(irq_o), 0);
        chk("R5", "fill after pop", longint'(fill_o), 0);
        man_pops = 1;
        tick(2);
        chk("R5", "fill after pop on empty", longint'(fill_o), 0);
        man_pops = 0;

        // R2 disabled line
        toggle(one(40), 10, 1'b0);
        chk("R2", "fill after disabled line", longint'(fill_o), 0);

        // R3 R4 simultaneous changes, rising then falling
        mon_en = 1'b1;
        wr_en(1, 32'h0000_0002);
        toggle(one(33) | one(7) | one(2) | one(3), 20, 1'b0);
        toggle(one(33) | one(7) | one(2) | one(3), 20, 1'b0);
        chk("R3", "burst drained", exp_q.size(), 0);

        // R2 top slice, out-of-range slice ignored
        wr_en(2, 32'h8000_0000);
        toggle(one(95), 10, 1'b0);
        wr_en(3, 32'hFFFF_FFFF);
        toggle(one(64), 10, 1'b0);
        chk("R2", "no event from ignored slice write", exp_q.size(), 0);
        chk("R2", "fill after ignored slice write", longint'(fill_o), 0);

        // R2 disabling one bit
        wr_en(0, 32'hFFFF_FFDF);
        toggle(one(5), 10, 1'b0);
        chk("R2", "fill after disabling line", longint'(fill_o), 0);

        // R6 R7 threshold
        mon_en = 1'b0;
        wr_thr(4);
        toggle(one(0) | one(1) | one(2), 8, 1'b0);
        chk("R7", "fill below threshold", longint'(fill_o), 3);
        chk("R7", "irq below threshold", longint'(irq_o), 0);
        toggle(one(3), 8, 1'b0);
        chk("R7", "irq at threshold", longint'(irq_o), 1);
        man_pops = 1;
        tick(2);
        chk("R7", "irq after pop below threshold", longint'(irq_o), 0);
        wr_thr(0);
        chk("R6", "threshold 0 stored as 1", longint'(irq_o), 1);
        mon_en = 1'b1;
        tick(10);
        mon_en = 1'b0;

        // R5 R8 full queue and overflow, R6 clamp at 256
        wr_en(0, 32'hFFFF_FFFF);
        wr_en(1, 32'hFFFF_FFFF);
        wr_en(2, 32'hFFFF_FFFF);
        wr_thr(300);
        toggle('1, N + 8, 1'b0);
        toggle('1, N + 8, 1'b0);
        chk("R7", "irq at 192 entries", longint'(irq_o), 0);
        toggle({{(N-64){1'b0}}, {64{1'b1}}}, 72, 1'b0);
        chk("R5", "fill when full", longint'(fill_o), 256);
        chk("R6", "irq at clamped threshold 256", longint'(irq_o), 1);
        chk("R8", "ovf before drop", longint'(ovf_o), 0);
        toggle(one(70), 10, 1'b1);
        chk("R8", "ovf after drop", longint'(ovf_o), 1);
        chk("R8", "fill after drop", longint'(fill_o), 256);
        clr_ovf();
        chk("R8", "ovf after clear", longint'(ovf_o), 0);
        mon_en = 1'b1;
        tick(300);
        chk("R5", "full queue drained", exp_q.size(), 0);

        // R9 second change while first still waiting
        wr_thr(1);
        toggle({{(N-32){1'b0}}, {32{1'b1}}}, 0, 1'b0);
        toggle(one(31), 50, 1'b1);
        chk("R9", "ovf after collision", longint'(ovf_o), 1);
        chk("R9", "collision burst drained", exp_q.size(), 0);
        chk("R9", "fill after collision burst", longint'(fill_o), 0);

        tick(5);
        finish_run();
    end
endmodule